// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block walks a DDR SDRAM through its power-up command sequence after a single start pulse. It sends a series of 4-bit command codes to the memory controller's command-issue port, each marked by a one-cycle valid strobe. An internal cycle counter enforces the minimum spacing between commands. All delays are parameters counted in clock cycles: the power-up deselect wait, the generic command gap, the mode-register delay (tMRD), the precharge delay (tRP) and the refresh-cycle delay (tRFC).

The refresh value output is forced to zero from the start of the sequence so that no refresh is issued while the device is being set up. In the same cycle as the final normal-operation command, the output is loaded with the programmed refresh value and a done flag rises. The CAS latency choice (2 or 2.5) is sampled at start and selects the low bit of both mode-register-set codes. The done flag stays high until the next start pulse, and that pulse runs the whole sequence again. A start pulse that arrives while a sequence is running is ignored.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset, `cmd_valid_o`, `done_o` and `refresh_o` are all 0, and no command is issued until a start pulse is seen.
- R2: A start accepted at clock edge E0 gives `refresh_o` = 0 from E0 until the final command. The first command, NOP (code 4'b0101), is strobed at edge E0 + DESEL_CYC.
- R3: The commands come in this fixed order: NOP 0101, precharge-all 0100, DLL-enable extended mode set 0110, mode set with DLL reset 001c, precharge-all 0100, auto-refresh 0111, auto-refresh 0111, mode set without DLL reset 000c, normal operation 1111. Here c is the CAS-latency bit.
- R4: The bit c is `cl_half_i` sampled at the accepted start (0 selects CL 2, 1 selects CL 2.5). Changing `cl_half_i` later has no effect on the sequence in progress.
- R5: Strobe-to-strobe spacing in cycles is as follows. NOP to precharge, precharge to extended mode set, and mode set to normal operation: GAP_CYC. Extended mode set to first mode set, and first mode set to second precharge: TMRD_CYC. Second precharge to first auto-refresh: TRP_CYC. First to second auto-refresh, and second auto-refresh to the final mode set: TRFC_CYC.
- R6: `cmd_valid_o` is high for exactly one cycle per command and low in every cycle between commands.
- R7: On the edge that strobes the normal-operation command, `done_o` goes to 1 and `refresh_o` takes the value of `refresh_val_i`.
- R8: A start pulse while the sequence is running is ignored: the order and timing of the remaining commands are unchanged.
- R9: `done_o` and `refresh_o` hold after completion until the next start pulse. That pulse clears `done_o`, zeroes `refresh_o` and restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for the initialization sequence |
| cl_half_i | input | 1 | CAS latency select: 0 gives 2, 1 gives 2.5 |
| refresh_val_i | input | REF_W | Refresh value to load at completion |
| cmd_o | output | 4 | Command code to the controller command port |
| cmd_valid_o | output | 1 | One-cycle strobe that qualifies `cmd_o` |
| refresh_o | output | REF_W | Refresh value; zero while the sequence runs |
| done_o | output | 1 | Sequence complete flag |

## Verification
The bench checks the exact strobe cycle of every command and checks that the strobe stays low in every cycle between commands. An off-by-one counter reload would shift a strobe by a cycle, and a mixed-up gap table would put a tRFC spacing where tMRD belongs; both are caught at the first misplaced strobe.

`cl_half_i` is flipped right after start to catch a design that reads the live input instead of the sampled one, because the mode-set low bits would then come out wrong. A start pulse is injected mid-sequence to catch a design that restarts or stalls. Idle cycles after completion confirm that done and the refresh value do not decay. The next run confirms that a fresh start zeroes the refresh value before the NOP.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [3:0] {
        CMD_MRS        = 4'b0000,
        CMD_MRS_DLLRST = 4'b0010,
        CMD_PRECHARGE  = 4'b0100,
        CMD_NOP        = 4'b0101,
        CMD_EMRS_DLL   = 4'b0110,
        CMD_AUTOREF    = 4'b0111,
        CMD_NORMAL     = 4'b1111
    } ddr_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    localparam int NUM_STEPS = 9;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int LAST_STEP = NUM_STEPS - 1;

    typedef logic [STEP_W-1:0] step_t;

endpackage

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
(
    input  step_t      step_i,
    input  logic       cl_half_i,
    output logic [3:0] code_o
);

    always_comb begin
        case (step_i)
            step_t'(0): code_o = CMD_NOP;
            step_t'(1): code_o = CMD_PRECHARGE;
            step_t'(2): code_o = CMD_EMRS_DLL;
            step_t'(3): code_o = CMD_MRS_DLLRST | {3'b000, cl_half_i};
            step_t'(4): code_o = CMD_PRECHARGE;
            step_t'(5): code_o = CMD_AUTOREF;
            step_t'(6): code_o = CMD_AUTOREF;
            step_t'(7): code_o = CMD_MRS | {3'b000, cl_half_i};
            default:    code_o = CMD_NORMAL;
        endcase
    end

endmodule

// File: rtl/ddr_init_gap_timer.sv
module ddr_init_gap_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    AST_TMR_STAYS_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o); // R5

    AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !expired_o) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int DESEL_CYC = 40000,
    parameter int GAP_CYC   = 2,
    parameter int TMRD_CYC  = 4,
    parameter int TRP_CYC   = 4,
    parameter int TRFC_CYC  = 16,
    parameter int REF_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cl_half_i,
    input  logic [REF_W-1:0] refresh_val_i,
    output logic [3:0]       cmd_o,
    output logic             cmd_valid_o,
    output logic [REF_W-1:0] refresh_o,
    output logic             done_o
);

    localparam int MAX_A   = (DESEL_CYC > GAP_CYC)  ? DESEL_CYC : GAP_CYC;
    localparam int MAX_B   = (TMRD_CYC  > TRP_CYC)  ? TMRD_CYC  : TRP_CYC;
    localparam int MAX_C   = (MAX_A     > MAX_B)    ? MAX_A     : MAX_B;
    localparam int MAX_GAP = (MAX_C     > TRFC_CYC) ? MAX_C     : TRFC_CYC;
    localparam int CNT_W   = $clog2(MAX_GAP + 1);

    typedef struct packed {
        seq_state_e       state;
        step_t            step;
        logic             cl_half;
        logic [3:0]       cmd;
        logic             cmd_valid;
        logic [REF_W-1:0] refresh;
        logic             done;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [3:0]       step_code;
    step_t            next_step;
    logic [CNT_W-1:0] next_gap;

    ddr_init_cmd_enc u_enc (
        .step_i    (r_q.step),
        .cl_half_i (r_q.cl_half),
        .code_o    (step_code)
    );

    ddr_init_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    // Spacing that must elapse before the command at next_step.
    always_comb begin
        next_step = r_q.step + 1'b1;
        case (next_step)
            step_t'(3), step_t'(4): next_gap = CNT_W'(TMRD_CYC - 1);
            step_t'(5):             next_gap = CNT_W'(TRP_CYC - 1);
            step_t'(6), step_t'(7): next_gap = CNT_W'(TRFC_CYC - 1);
            default:                next_gap = CNT_W'(GAP_CYC - 1);
        endcase
    end

    always_comb begin
        r_d           = r_q;
        r_d.cmd_valid = 1'b0;
        tmr_load      = 1'b0;
        tmr_val       = '0;
        case (r_q.state)
            ST_BUSY: begin
                if (tmr_expired) begin
                    r_d.cmd_valid = 1'b1;
                    r_d.cmd       = step_code;
                    if (r_q.step == step_t'(LAST_STEP)) begin
                        r_d.state   = ST_DONE;
                        r_d.done    = 1'b1;
                        r_d.refresh = refresh_val_i;
                    end else begin
                        r_d.step = next_step;
                        tmr_load = 1'b1;
                        tmr_val  = next_gap;
                    end
                end
            end
            default: begin
                if (start_i) begin
                    r_d.state   = ST_BUSY;
                    r_d.step    = '0;
                    r_d.cl_half = cl_half_i;
                    r_d.refresh = '0;
                    r_d.done    = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(DESEL_CYC - 1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.step      <= '0;
            r_q.cl_half   <= 1'b0;
            r_q.cmd       <= '0;
            r_q.cmd_valid <= 1'b0;
            r_q.refresh   <= '0;
            r_q.done      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_o       = r_q.cmd;
    assign cmd_valid_o = r_q.cmd_valid;
    assign refresh_o   = r_q.refresh;
    assign done_o      = r_q.done;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o); // R6

    AST_REFRESH_OFF_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_BUSY) |-> (refresh_o == '0 && !done_o)); // R2

    AST_MRS_CL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o[3:2] == 2'b00) |-> (cmd_o[0] == r_q.cl_half)); // R4

    AST_NORMAL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o == CMD_NORMAL) |-> done_o); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_BUSY && start_i && !tmr_expired)
        |=> (r_q.state == ST_BUSY && r_q.step == $past(r_q.step))); // R8

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(refresh_o))); // R9

endmodule

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;

    localparam int DESEL = 20;
    localparam int GAP   = 2;
    localparam int TMRD  = 4;
    localparam int TRP   = 4;
    localparam int TRFC  = 16;
    localparam int REF_W = 8;

    // Stimulus/expectation table: gap before each command and its base code.
    localparam int         GAPS  [9] = '{DESEL, GAP, GAP, TMRD, TMRD, TRP, TRFC, TRFC, GAP};
    localparam logic [3:0] CODES [9] = '{4'h5, 4'h4, 4'h6, 4'h2, 4'h4, 4'h7, 4'h7, 4'h0, 4'hF};

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_i;
    logic             cl_half_i;
    logic [REF_W-1:0] refresh_val_i;
    logic [3:0]       cmd_o;
    logic             cmd_valid_o;
    logic [REF_W-1:0] refresh_o;
    logic             done_o;

    int  n_checks = 0;
    int  n_errs   = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    ddr_init_seq #(
        .DESEL_CYC (DESEL),
        .GAP_CYC   (GAP),
        .TMRD_CYC  (TMRD),
        .TRP_CYC   (TRP),
        .TRFC_CYC  (TRFC),
        .REF_W     (REF_W)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .cl_half_i     (cl_half_i),
        .refresh_val_i (refresh_val_i),
        .cmd_o         (cmd_o),
        .cmd_valid_o   (cmd_valid_o),
        .refresh_o     (refresh_o),
        .done_o        (done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Run one full sequence; poke injects a start pulse mid-sequence (R8).
    task automatic run_seq(input logic cl, input logic [REF_W-1:0] rv, input bit poke);
        @(negedge clk);
        start_i       = 1'b1;
        cl_half_i     = cl;
        refresh_val_i = rv;
        @(negedge clk);
        start_i   = 1'b0;
        cl_half_i = ~cl;  // R4: later changes must not matter
        chk(refresh_o == '0 && !done_o && !cmd_valid_o, "R2/R9",
            "refresh zero and done cleared after start", {refresh_o, 3'b0, done_o}, 0);
        for (int i = 0; i < 9; i++) begin
            bit quiet = 1'b1;
            logic [3:0] exp_code = CODES[i] | ((i == 3 || i == 7) ? {3'b000, cl} : 4'b0000);
            for (int k = 1; k <= GAPS[i]; k++) begin
                @(negedge clk);
                if (poke) begin
                    if (i == 2 && k == 1) start_i = 1'b1;
                    else                  start_i = 1'b0;
                end
                if (k < GAPS[i]) begin
                    if (cmd_valid_o || done_o || refresh_o != '0) quiet = 1'b0;
                end
            end
            chk(quiet, "R5/R6/R8", $sformatf("no strobe and refresh off before step %0d", i),
                {31'b0, quiet}, 1);
            chk(cmd_valid_o && cmd_o == exp_code, "R3/R4/R5",
                $sformatf("command at step %0d", i), {27'b0, cmd_valid_o, cmd_o},
                {27'b0, 1'b1, exp_code});
        end
        chk(done_o && refresh_o == rv, "R7", "done and refresh value at completion",
            {23'b0, done_o, refresh_o}, {23'b0, 1'b1, rv});
        @(negedge clk);
        chk(!cmd_valid_o, "R6", "strobe drops after final command", {31'b0, cmd_valid_o}, 0);
    endtask

    initial begin
        rst_n         = 1'b0;
        start_i       = 1'b0;
        cl_half_i     = 1'b0;
        refresh_val_i = '0;
        repeat (3) @(negedge clk);
        chk(!cmd_valid_o && !done_o && refresh_o == '0, "R1", "outputs in reset",
            {23'b0, done_o, refresh_o}, 0);
        rst_n = 1'b1;
        begin
            bit idle_ok = 1'b1;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (cmd_valid_o || done_o || refresh_o != '0) idle_ok = 1'b0;
            end
            chk(idle_ok, "R1", "no activity without start", {31'b0, idle_ok}, 1);
        end

        run_seq(1'b0, 8'h5A, 1'b0);

        begin
            bit hold_ok = 1'b1;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (!done_o || refresh_o != 8'h5A || cmd_valid_o) hold_ok = 1'b0;
            end
            chk(hold_ok, "R9", "done and refresh hold while idle", {31'b0, hold_ok}, 1);
        end

        run_seq(1'b1, 8'hC3, 1'b1);   // R9 restart from done, R8 poke, R4 CL 2.5
        run_seq(1'b0, 8'h11, 1'b1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

endmodule